// File: doc/BRIEF.md
# SPI Serial EEPROM Target

This block is the device side of a small serial EEPROM. It holds 2048 bytes and is controlled from an SPI host in mode 0. The pins `sck`, `cs_n` and `si` are asynchronous to the system clock. Two flip-flop stages bring them into the system clock domain, and edge detectors then find the SCK and chip-select transitions. A frame begins when `cs_n` falls. The first 8 bits on `si` form the command byte. Read and write commands are followed by a 16-bit address, most significant bit first. Only the low 11 address bits are used; the top five are don't-care.

There are four commands:
- **Write enable** sets the write-enable latch.
- **Status read** streams back a status byte. Bit 0 is the busy flag and bit 1 is the latch.
- **Read** streams array bytes from an auto-incrementing address that wraps over the whole array.
- **Write** collects data into a 32-byte page buffer. The buffer is committed to the array only if the latch was set beforehand and `cs_n` rises right after a complete byte.

A commit starts an internal programming cycle of `PROG_CYCLES` system clocks. During that cycle only the status read is honoured. The latch clears when the cycle ends.

The SPI host paces every transfer, so the block exerts no back-pressure. The output is framed only by `so_oe`; outside a data phase `so` is held at 0.

Top module: `spi_eeprom`

## Requirements
- R1: After reset, `so` and `so_oe` are 0 and a status read returns 0x00.
- R2: Command 0x06 sets the write-enable latch, so a following status read (command 0x05) returns bit 1 = 1, i.e. 0x02.
- R3: Command 0x03 followed by a 16-bit address returns the byte at address bits 10..0, MSB first. Address bits 15..11 are ignored. `so` changes after SCK falls and is valid at the next rising edge.
- R4: While `cs_n` stays low in a read, further bytes stream from consecutive addresses, and address 0x7FF is followed by 0x000.
- R5: Command 0x02 with the latch clear is ignored. The array is unchanged and status stays 0x00.
- R6: Write data bytes land at consecutive addresses in which only bits 4..0 advance. Beyond 32 bytes the offset wraps within the page, and later bytes overwrite earlier ones.
- R7: If `cs_n` rises while a data byte is only partly shifted in, nothing is written, no programming starts, and the latch stays set (status 0x02).
- R8: After a committed write, status bit 0 reads 1 (status 0x03) until `PROG_CYCLES` system clocks have passed, then 0.
- R9: While programming, every command except 0x05 is ignored. A read keeps `so_oe` low and a write changes nothing.
- R10: The latch is cleared when programming completes, so status reads 0x00 afterwards.
- R11: An unknown command keeps `so_oe` low until `cs_n` rises, and the next frame behaves normally.
- R12: A status read repeats the status byte for as long as SCK keeps clocking with `cs_n` low.
- R13: `so_oe` is high only while status or read data is being shifted out, and `so` is 0 whenever `so_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host, mode 0 |
| cs_n | input | 1 | Active-low chip select framing each command |
| si | input | 1 | Serial data in, sampled on SCK rising edges |
| so | output | 1 | Serial data out, updated after SCK falling edges |
| so_oe | output | 1 | High while `so` carries data |

## Verification
Single-byte and multi-byte page writes are read back as streams. This shows whether the address counter advances and whether reads cross the top of the array into address 0. A 34-byte write that starts two bytes before the end of its page separates page-local wrap and overwrite from a carry into the upper address bits. Four further patterns separate the commit rules from plain data movement:
- a write without the latch,
- a frame cut off mid-byte,
- reads and writes issued while the programming cycle runs,
- an unknown command.

Status is read repeatedly to follow the busy flag and the latch through each case.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_RD,
    ST_WR,
    ST_STAT,
    ST_SKIP
  } st_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST;
        else        pipe[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     we,
  input  logic [PAGE_W-1:0]        idx,
  input  logic [7:0]               wdata,
  input  logic                     commit,
  input  logic [ADDR_W-PAGE_W-1:0] hi,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [7:0]               mem_wdata
);
  localparam int DEPTH = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - PAGE_W;

  logic [7:0]       slot [DEPTH];
  logic [DEPTH-1:0] valid;
  logic             active;
  logic [PAGE_W-1:0] fidx;
  logic [HI_W-1:0]  hi_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && idx == PAGE_W'(g)) slot[g] <= wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       valid[g] <= 1'b0;
      else if (clr)                     valid[g] <= 1'b0;
      else if (we && idx == PAGE_W'(g)) valid[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      fidx   <= '0;
      hi_q   <= '0;
    end else if (commit) begin
      active <= 1'b1;
      fidx   <= '0;
      hi_q   <= hi;
    end else if (active) begin
      fidx <= fidx + PAGE_W'(1);
      if (fidx == {PAGE_W{1'b1}}) active <= 1'b0;
    end
  end

  assign mem_we    = active & valid[fidx];
  assign mem_addr  = {hi_q, fidx};
  assign mem_wdata = slot[fidx];
endmodule

// File: rtl/spi_eeprom.sv
module spi_eeprom
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 5,
  parameter int PROG_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_oe
);
  localparam int SR_W   = (ADDR_W > 8) ? ADDR_W : 8;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int PROG_W = $clog2(PROG_CYCLES + 1);

  logic sck_s, cs_s, si_s, sck_d, cs_d;
  logic sck_rise, sck_fall, cs_fall, cs_rise;

  spi_ee_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sck, cs_n, si}),
    .q     ({sck_s, cs_s, si_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign cs_fall  = ~cs_s & cs_d;
  assign cs_rise  = cs_s & ~cs_d;

  st_e               state;
  logic [4:0]        hcnt;
  logic [SR_W-1:0]   sr, sr_nx;
  logic [7:0]        op_nx;
  logic [ADDR_W-1:0] hdr_addr;
  logic              is_read;
  logic [2:0]        dcnt, ocnt;
  logic [6:0]        dsr;
  logic              wbyte_ok;
  logic [ADDR_W-1:0] rd_addr;
  logic [PAGE_W-1:0] wr_off;
  logic [HI_W-1:0]   page_hi;
  logic              wel_q;
  logic [PROG_W-1:0] prog_cnt;
  logic              busy;
  logic              pb_clr, pb_we, pb_commit;
  logic [PAGE_W-1:0] pb_idx;
  logic [7:0]        pb_data;
  logic              arr_we;
  logic [ADDR_W-1:0] arr_waddr;
  logic [7:0]        arr_wdata, arr_rdata, tx_byte;
  logic              so_q, oe_q;

  assign sr_nx    = {sr[SR_W-2:0], si_s};
  assign op_nx    = sr_nx[7:0];
  assign hdr_addr = sr_nx[ADDR_W-1:0];
  assign busy     = (prog_cnt != '0);
  assign tx_byte  = (state == ST_RD) ? arr_rdata : {6'b0, wel_q, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      hcnt      <= '0;
      sr        <= '0;
      is_read   <= 1'b0;
      dcnt      <= '0;
      ocnt      <= '0;
      dsr       <= '0;
      wbyte_ok  <= 1'b0;
      rd_addr   <= '0;
      wr_off    <= '0;
      page_hi   <= '0;
      wel_q     <= 1'b0;
      prog_cnt  <= '0;
      pb_clr    <= 1'b0;
      pb_we     <= 1'b0;
      pb_commit <= 1'b0;
      pb_idx    <= '0;
      pb_data   <= '0;
      so_q      <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      pb_clr    <= 1'b0;
      pb_we     <= 1'b0;
      pb_commit <= 1'b0;
      if (busy) begin
        prog_cnt <= prog_cnt - PROG_W'(1);
        if (prog_cnt == PROG_W'(1)) wel_q <= 1'b0;
      end
      if (cs_fall) begin
        state <= ST_HDR;
        hcnt  <= '0;
        ocnt  <= '0;
        so_q  <= 1'b0;
        oe_q  <= 1'b0;
      end else if (cs_s) begin
        if (cs_rise && state == ST_WR && wbyte_ok) begin
          prog_cnt  <= PROG_W'(PROG_CYCLES);
          pb_commit <= 1'b1;
        end
        state <= ST_IDLE;
        so_q  <= 1'b0;
        oe_q  <= 1'b0;
      end else begin
        if (sck_rise) begin
          case (state)
            ST_HDR: begin
              sr   <= sr_nx;
              hcnt <= hcnt + 5'd1;
              if (hcnt == 5'd7) begin
                if (busy && op_nx != OP_RDSR) state <= ST_SKIP;
                else begin
                  case (op_nx)
                    OP_WREN: begin
                      wel_q <= 1'b1;
                      state <= ST_SKIP;
                    end
                    OP_RDSR: state <= ST_STAT;
                    OP_READ: is_read <= 1'b1;
                    OP_WRITE: begin
                      if (wel_q) begin
                        is_read <= 1'b0;
                        pb_clr  <= 1'b1;
                      end else state <= ST_SKIP;
                    end
                    default: state <= ST_SKIP;
                  endcase
                end
              end
              if (hcnt == 5'd23) begin
                if (is_read) begin
                  rd_addr <= hdr_addr;
                  state   <= ST_RD;
                end else begin
                  wr_off   <= hdr_addr[PAGE_W-1:0];
                  page_hi  <= hdr_addr[ADDR_W-1:PAGE_W];
                  dcnt     <= '0;
                  wbyte_ok <= 1'b0;
                  state    <= ST_WR;
                end
              end
            end
            ST_WR: begin
              dsr  <= {dsr[5:0], si_s};
              dcnt <= dcnt + 3'd1;
              if (dcnt == 3'd7) begin
                pb_we    <= 1'b1;
                pb_idx   <= wr_off;
                pb_data  <= {dsr, si_s};
                wr_off   <= wr_off + PAGE_W'(1);
                wbyte_ok <= 1'b1;
              end else begin
                wbyte_ok <= 1'b0;
              end
            end
            default: ;
          endcase
        end
        if (sck_fall && (state == ST_RD || state == ST_STAT)) begin
          so_q <= tx_byte[~ocnt];
          oe_q <= 1'b1;
          ocnt <= ocnt + 3'd1;
          if (ocnt == 3'd7 && state == ST_RD) rd_addr <= rd_addr + ADDR_W'(1);
        end
      end
    end
  end

  spi_ee_pagebuf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_page (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (pb_clr),
    .we        (pb_we),
    .idx       (pb_idx),
    .wdata     (pb_data),
    .commit    (pb_commit),
    .hi        (page_hi),
    .mem_we    (arr_we),
    .mem_addr  (arr_waddr),
    .mem_wdata (arr_wdata)
  );

  spi_ee_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (arr_we),
    .waddr (arr_waddr),
    .wdata (arr_wdata),
    .raddr (rd_addr),
    .rdata (arr_rdata)
  );

  assign so    = so_q;
  assign so_oe = oe_q;
endmodule

// File: rtl/spi_ee_chk.sv
module spi_ee_chk
  import spi_ee_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic so,
  input logic so_oe,
  input logic busy,
  input logic wel,
  input st_e  st,
  input logic mem_we
);
  // R13: output held low when not driven
  p_so_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !so_oe |-> !so);

  // R8: programming only runs with the latch set
  p_busy_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wel);

  // R8: array changes only inside a programming cycle
  p_array_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R10: latch drops when programming ends
  p_wel_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  // R9: no read or write data phase during programming
  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st != ST_RD && st != ST_WR));
endmodule

bind spi_eeprom spi_ee_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .so     (so),
  .so_oe  (so_oe),
  .busy   (busy),
  .wel    (wel_q),
  .st     (state),
  .mem_we (arr_we)
);

// File: tb/spi_eeprom_tb.sv
module spi_eeprom_tb;
  localparam int HALF = 8;
  localparam int PROG = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic si = 1'b0;
  logic so, so_oe;

  always #2 clk = ~clk;

  spi_eeprom #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .so(so), .so_oe(so_oe)
  );

  int nchk = 0, nbad = 0;
  bit done = 1'b0;
  bit oe_seen;
  bit mon_cap = 1'b0;
  logic [7:0] model [2048];
  logic [7:0] wq [$];
  logic [7:0] exp_q [$];
  string tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic xbit(input logic b, output logic r);
    si = b;
    tick();
    r = so;
    if (so_oe) oe_seen = 1'b1;
    sck = 1'b1;
    tick();
    sck = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    tick();
  endtask

  task automatic cs_hi();
    tick();
    cs_n = 1'b1;
    tick();
  endtask

  task automatic wren();
    logic [7:0] d;
    cs_lo(); xbyte(8'h06, d); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_lo(); xbyte(8'h05, d); xbyte(8'h00, s); cs_hi();
  endtask

  task automatic wait_ready(output int polls);
    logic [7:0] s;
    polls = 0;
    for (int i = 0; i < 200; i++) begin
      rdsr(s);
      polls++;
      if (!s[0]) break;
    end
  endtask

  task automatic write_frame(input logic [15:0] a, input int extra_bits, input bit upd);
    logic [7:0] d;
    logic [4:0] off;
    logic r;
    cs_lo();
    xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    off = a[4:0];
    for (int i = 0; i < wq.size(); i++) begin
      xbyte(wq[i], d);
      if (upd) model[{a[10:5], off}] = wq[i];
      off++;
    end
    for (int i = 0; i < extra_bits; i++) xbit(1'b1, r);
    cs_hi();
    wq.delete();
  endtask

  task automatic read_expect(input logic [15:0] a, input int n, input string tag);
    logic [7:0] d;
    cs_lo();
    xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model[(int'(a) + k) & 2047]);
      tag_q.push_back(tag);
    end
    mon_cap = 1'b1;
    for (int k = 0; k < n; k++) xbyte(8'h00, d);
    mon_cap = 1'b0;
    cs_hi();
  endtask

  // monitor: collects read data at SCK rising edges and compares with scoreboard
  initial begin
    logic [7:0] mb;
    int mcnt;
    bit miss;
    mb = 0; mcnt = 0; miss = 0;
    forever begin
      @(posedge sck);
      if (mon_cap) begin
        mb = {mb[6:0], so};
        if (!so_oe) miss = 1'b1;
        mcnt++;
        if (mcnt == 8) begin
          mcnt = 0;
          if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", mb, 0);
          else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(mb == e && !miss, t, {miss, mb}, e);
          end
          miss = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    int polls;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk(so == 1'b0 && so_oe == 1'b0, "R1 pins after reset", {so_oe, so}, 0);
    chk(so_oe == 1'b0, "R13 oe idle", so_oe, 0);
    rdsr(s);
    chk(s == 8'h00, "R1 status after reset", s, 8'h00);

    wren();
    rdsr(s);
    chk(s == 8'h02, "R2 latch set", s, 8'h02);
    cs_lo(); xbyte(8'h05, d);
    for (int i = 0; i < 3; i++) begin
      xbyte(8'h00, s);
      chk(s == 8'h02, "R12 repeated status", s, 8'h02);
    end
    cs_hi();

    // write with ignored upper address bits
    wq = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};
    write_frame(16'hF810, 0, 1'b1);
    rdsr(s);
    chk(s == 8'h03, "R8 busy after commit", s, 8'h03);
    wait_ready(polls);
    chk(polls > 1, "R8 busy lasts", polls, 2);
    rdsr(s);
    chk(s == 8'h00, "R10 latch cleared", s, 8'h00);
    read_expect(16'h0010, 4, "R3 read stream");

    // write without latch
    wq = '{8'h55};
    write_frame(16'h0010, 0, 1'b0);
    rdsr(s);
    chk(s == 8'h00, "R5 no busy without latch", s, 8'h00);
    read_expect(16'h0010, 1, "R5 data unchanged");

    // page wrap with overwrite
    wren();
    for (int k = 0; k < 34; k++) wq.push_back(8'(8'h40 + k));
    write_frame(16'h003E, 0, 1'b1);
    wait_ready(polls);
    read_expect(16'h0020, 32, "R6 page wrap");

    // partial byte
    wren();
    wq = '{8'h99};
    write_frame(16'h0010, 3, 1'b0);
    rdsr(s);
    chk(s == 8'h02, "R7 partial byte not committed", s, 8'h02);
    read_expect(16'h0010, 1, "R7 data unchanged");

    // commands during programming
    wq = '{8'h77};
    write_frame(16'h0011, 0, 1'b1);
    oe_seen = 1'b0;
    cs_lo();
    xbyte(8'h03, d); xbyte(8'h00, d); xbyte(8'h10, d); xbyte(8'h00, d);
    cs_hi();
    chk(!oe_seen, "R9 read ignored while busy", oe_seen, 0);
    wq = '{8'h66};
    write_frame(16'h0012, 0, 1'b0);
    rdsr(s);
    chk(s == 8'h03, "R9 status allowed while busy", s, 8'h03);
    wait_ready(polls);
    rdsr(s);
    chk(s == 8'h00, "R10 latch cleared again", s, 8'h00);
    read_expect(16'h0010, 3, "R9 write ignored while busy");

    // unknown opcode
    oe_seen = 1'b0;
    cs_lo();
    xbyte(8'hAB, d); xbyte(8'h00, d); xbyte(8'h00, d);
    cs_hi();
    chk(!oe_seen, "R11 unknown opcode silent", oe_seen, 0);
    rdsr(s);
    chk(s == 8'h00, "R11 next frame normal", s, 8'h00);

    // wrap across top of array
    wren();
    wq = '{8'hC1, 8'hC2};
    write_frame(16'h07FE, 0, 1'b1);
    wait_ready(polls);
    wren();
    wq = '{8'hD1, 8'hD2};
    write_frame(16'h0000, 0, 1'b1);
    wait_ready(polls);
    read_expect(16'h07FE, 4, "R4 array wrap");
    #1;
    chk(so_oe == 1'b0 && so == 1'b0, "R13 idle after frame", {so_oe, so}, 0);

    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule